// File: doc/BRIEF.md
# Dual-Line Edge Interrupt Status Unit

This block watches a vector of already-synchronized input pins and records level transitions on each of them. Every pin has a programmable polarity that decides which of its two edges is the "assert" event; the opposite edge is the "deassert" event. Each kind of event has its own sticky status register and its own interrupt request line, so software can handle the two edge directions from separate handlers.

Software reaches the block through a simple register port: a write strobe with a write address and data, and a combinational readback selected by a read address. Four registers are visible: a per-pin interrupt enable, a per-pin polarity, and the two status words. A status word packs pin n into bit n+1. Its bit 0 is not a status bit. On a write, bit 0 picks the write mode: with bit 0 low, ones in the upper bits clear status; with bit 0 high, they set status, which lets software inject events.

Status bits record events whether or not the pin is enabled. The enable register only gates which recorded bits drive each interrupt line.

Top module: `edge_irq_unit`

## Requirements
- R1: While reset is applied and right after it is released, the enable, polarity and both status registers read as zero and both interrupt lines are low.
- R2: In a status register, pin n is held in bit n+1, and bit 0 of a status readback is always 0.
- R3: With a pin's polarity bit at 1, a rising edge sets that pin's bit in the assert status register and a falling edge sets it in the deassert status register.
- R4: With a pin's polarity bit at 0, a falling edge sets that pin's bit in the assert status register and a rising edge sets it in the deassert status register.
- R5: A status write with data bit 0 = 0 clears every status bit whose data bit is 1 and leaves the others unchanged.
- R6: A status write with data bit 0 = 1 sets every status bit whose data bit is 1 and leaves the others unchanged.
- R7: An edge on a pin in the same cycle as a write that clears that pin's status bit leaves the bit set.
- R8: Status bits latch whether or not the pin is enabled; each interrupt line is high exactly when its status register has a set bit for a pin whose enable bit is 1.
- R9: The pin levels seen on the first clock after reset are not treated as edges.
- R10: Register addresses are 0 for enable, 1 for polarity, 2 for assert status and 3 for deassert status. Enable and polarity hold pin n in bit n, and their top bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | NUM_PINS | Synchronized pin levels |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | NUM_PINS+1 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | NUM_PINS+1 | Register readback, combinational on rd_addr_i |
| irq_assert_o | output | 1 | Interrupt for enabled assert events |
| irq_deassert_o | output | 1 | Interrupt for enabled deassert events |

## Verification
A pin change presented before a clock edge is compared against the previous level at that edge, so the status bit and the interrupt line change together one edge later; a register write is likewise visible one edge after its strobe, and readback itself costs no cycle. The bench drives every input on the falling edge, lets exactly one rising edge pass, and samples all four registers and both lines on the next falling edge against its own register model. Directed steps pin down the exact bit positions, the write-mode choice, the edge-beats-clear case and the first cycle after reset, and a long seeded random run mixes pin toggles with writes to every address.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

    // Register selector; the status registers sit at the two upper addresses
    typedef enum logic [1:0] {
        REG_ENABLE        = 2'd0,
        REG_POLARITY      = 2'd1,
        REG_STAT_ASSERT   = 2'd2,
        REG_STAT_DEASSERT = 2'd3
    } reg_sel_e;

    // Meaning of bit 0 in a status write
    typedef enum logic {
        WMODE_CLEAR = 1'b0,
        WMODE_SET   = 1'b1
    } wmode_e;

    localparam int unsigned NUM_EVENT_KINDS = 2;

endpackage

// File: rtl/edge_irq_detect.sv
module edge_irq_detect #(
    parameter int unsigned NUM_PINS = 31
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_PINS-1:0] pins_i,
    input  logic [NUM_PINS-1:0] pol_i,
    output logic [NUM_PINS-1:0] ev_assert_o,
    output logic [NUM_PINS-1:0] ev_deassert_o
);

    typedef struct packed {
        logic [NUM_PINS-1:0] prev;
        logic                armed;
    } det_state_t;

    det_state_t st_d, st_q;
    logic [NUM_PINS-1:0] rise, fall;

    always_comb begin
        st_d       = st_q;
        st_d.prev  = pins_i;
        st_d.armed = 1'b1;
        // No history exists before the first sample after reset
        rise = st_q.armed ? (pins_i & ~st_q.prev) : '0;
        fall = st_q.armed ? (~pins_i & st_q.prev) : '0;
        ev_assert_o   = (rise & pol_i) | (fall & ~pol_i);
        ev_deassert_o = (fall & pol_i) | (rise & ~pol_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/edge_irq_status.sv
module edge_irq_status
    import edge_irq_pkg::*;
#(
    parameter int unsigned NUM_PINS = 31,
    localparam int unsigned DATA_W  = NUM_PINS + 1
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                wr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    input  logic [NUM_PINS-1:0] ev_i,
    input  logic [NUM_PINS-1:0] en_i,
    output logic [NUM_PINS-1:0] stat_o,
    output logic                irq_o
);

    logic [NUM_PINS-1:0] stat_d, stat_q;
    logic [NUM_PINS-1:0] set_mask, clr_mask;
    wmode_e              wmode;

    always_comb begin
        wmode    = wmode_e'(wdata_i[0]);
        set_mask = '0;
        clr_mask = '0;
        if (wr_i) begin
            if (wmode == WMODE_SET) begin
                set_mask = wdata_i[DATA_W-1:1];
            end else begin
                clr_mask = wdata_i[DATA_W-1:1];
            end
        end
        // New events are ORed last so they win over a clear
        stat_d = ((stat_q & ~clr_mask) | set_mask) | ev_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign stat_o = stat_q;
    assign irq_o  = |(stat_q & en_i);

endmodule

// File: rtl/edge_irq_unit.sv
module edge_irq_unit
    import edge_irq_pkg::*;
#(
    parameter int unsigned NUM_PINS = 31,
    localparam int unsigned DATA_W  = NUM_PINS + 1
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_PINS-1:0] pins_i,
    input  logic                wr_en_i,
    input  logic [1:0]          wr_addr_i,
    input  logic [DATA_W-1:0]   wr_data_i,
    input  logic [1:0]          rd_addr_i,
    output logic [DATA_W-1:0]   rd_data_o,
    output logic                irq_assert_o,
    output logic                irq_deassert_o
);

    typedef struct packed {
        logic [NUM_PINS-1:0] en;
        logic [NUM_PINS-1:0] pol;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic [NUM_PINS-1:0] en_w, pol_w;
    logic [NUM_PINS-1:0] ev_arr   [NUM_EVENT_KINDS];
    logic [NUM_PINS-1:0] stat_arr [NUM_EVENT_KINDS];
    logic                irq_arr  [NUM_EVENT_KINDS];
    logic [NUM_PINS-1:0] stat_a, stat_d;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i && (reg_sel_e'(wr_addr_i) == REG_ENABLE)) begin
            cfg_d.en = wr_data_i[NUM_PINS-1:0];
        end
        if (wr_en_i && (reg_sel_e'(wr_addr_i) == REG_POLARITY)) begin
            cfg_d.pol = wr_data_i[NUM_PINS-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign en_w  = cfg_q.en;
    assign pol_w = cfg_q.pol;

    edge_irq_detect #(
        .NUM_PINS (NUM_PINS)
    ) detect_i (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .pins_i        (pins_i),
        .pol_i         (pol_w),
        .ev_assert_o   (ev_arr[0]),
        .ev_deassert_o (ev_arr[1])
    );

    for (genvar k = 0; k < NUM_EVENT_KINDS; k++) begin : g_stat
        localparam logic [1:0] SEL = 2'(REG_STAT_ASSERT) + 2'(k);
        logic wr_sel;
        assign wr_sel = wr_en_i && (wr_addr_i == SEL);

        edge_irq_status #(
            .NUM_PINS (NUM_PINS)
        ) status_i (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .wr_i    (wr_sel),
            .wdata_i (wr_data_i),
            .ev_i    (ev_arr[k]),
            .en_i    (en_w),
            .stat_o  (stat_arr[k]),
            .irq_o   (irq_arr[k])
        );
    end

    assign stat_a         = stat_arr[0];
    assign stat_d         = stat_arr[1];
    assign irq_assert_o   = irq_arr[0];
    assign irq_deassert_o = irq_arr[1];

    always_comb begin
        unique case (reg_sel_e'(rd_addr_i))
            REG_ENABLE:        rd_data_o = {1'b0, en_w};
            REG_POLARITY:      rd_data_o = {1'b0, pol_w};
            REG_STAT_ASSERT:   rd_data_o = {stat_a, 1'b0};
            REG_STAT_DEASSERT: rd_data_o = {stat_d, 1'b0};
            default:           rd_data_o = '0;
        endcase
    end

endmodule

// File: rtl/edge_irq_unit_chk.sv
module edge_irq_unit_chk
    import edge_irq_pkg::*;
#(
    parameter int unsigned NUM_PINS = 31,
    localparam int unsigned DATA_W  = NUM_PINS + 1
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic [NUM_PINS-1:0] pins_i,
    input logic                wr_en_i,
    input logic [1:0]          wr_addr_i,
    input logic [DATA_W-1:0]   wr_data_i,
    input logic [1:0]          rd_addr_i,
    input logic [DATA_W-1:0]   rd_data_o,
    input logic                irq_assert_o,
    input logic                irq_deassert_o,
    input logic [NUM_PINS-1:0] en_w,
    input logic [NUM_PINS-1:0] pol_w,
    input logic [NUM_PINS-1:0] stat_a,
    input logic [NUM_PINS-1:0] stat_d
);

    logic [NUM_PINS-1:0] seen_q;
    logic                live_q;
    logic [NUM_PINS-1:0] up, dn, exp_a, exp_d, wmask;
    logic                wr_a, wr_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seen_q <= '0;
            live_q <= 1'b0;
        end else begin
            seen_q <= pins_i;
            live_q <= 1'b1;
        end
    end

    assign up    = live_q ? (pins_i & ~seen_q) : '0;
    assign dn    = live_q ? (~pins_i & seen_q) : '0;
    assign exp_a = (up & pol_w) | (dn & ~pol_w);
    assign exp_d = (dn & pol_w) | (up & ~pol_w);
    assign wmask = wr_data_i[DATA_W-1:1];
    assign wr_a  = wr_en_i && (wr_addr_i == 2'(REG_STAT_ASSERT));
    assign wr_d  = wr_en_i && (wr_addr_i == 2'(REG_STAT_DEASSERT));

    // R2
    status_bit0_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((rd_addr_i == 2'(REG_STAT_ASSERT)) || (rd_addr_i == 2'(REG_STAT_DEASSERT)))
            |-> (rd_data_o[0] == 1'b0));

    // R3 R4 R7
    assert_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exp_a != '0) |=> ((stat_a & $past(exp_a)) == $past(exp_a)));

    // R3 R4 R7
    deassert_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exp_d != '0) |=> ((stat_d & $past(exp_d)) == $past(exp_d)));

    // R5
    clear_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_a && !wr_data_i[0]) |=> ((stat_a & $past(wmask & ~exp_a)) == '0));

    // R6
    set_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_d && wr_data_i[0]) |=> ((stat_d & $past(wmask)) == $past(wmask)));

    // R8
    sticky_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_a && !wr_d) |=> (((stat_a & $past(stat_a)) == $past(stat_a))
                              && ((stat_d & $past(stat_d)) == $past(stat_d))));

    // R8
    irq_gated_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_w == '0) |-> (!irq_assert_o && !irq_deassert_o));

    // R9
    first_sample_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!live_q && !wr_en_i) |=> ($stable(stat_a) && $stable(stat_d)));

endmodule

bind edge_irq_unit edge_irq_unit_chk #(
    .NUM_PINS (NUM_PINS)
) chk_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .pins_i         (pins_i),
    .wr_en_i        (wr_en_i),
    .wr_addr_i      (wr_addr_i),
    .wr_data_i      (wr_data_i),
    .rd_addr_i      (rd_addr_i),
    .rd_data_o      (rd_data_o),
    .irq_assert_o   (irq_assert_o),
    .irq_deassert_o (irq_deassert_o),
    .en_w           (en_w),
    .pol_w          (pol_w),
    .stat_a         (stat_a),
    .stat_d         (stat_d)
);

// File: tb/edge_irq_unit_tb_top.sv
module edge_irq_unit_tb_top;

    localparam int unsigned N  = 31;
    localparam int unsigned DW = N + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  pins = '0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [1:0]    rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          irq_a, irq_d;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Model state
    logic [N-1:0] m_en = '0, m_pol = '0, m_sa = '0, m_sd = '0, m_prev = '0;
    bit           m_armed = 1'b0;

    always #10 clk = ~clk;

    edge_irq_unit #(.NUM_PINS(N)) dut_i (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .pins_i         (pins),
        .wr_en_i        (wr_en),
        .wr_addr_i      (wr_addr),
        .wr_data_i      (wr_data),
        .rd_addr_i      (rd_addr),
        .rd_data_o      (rd_data),
        .irq_assert_o   (irq_a),
        .irq_deassert_o (irq_d)
    );

    function automatic logic [N-1:0] f_events(input logic [N-1:0] p, input logic [N-1:0] prv,
                                              input logic [N-1:0] pol, input bit armed,
                                              input bit want_assert);
        logic [N-1:0] r, f;
        r = armed ? (p & ~prv) : '0;
        f = armed ? (~p & prv) : '0;
        return want_assert ? ((r & pol) | (f & ~pol)) : ((f & pol) | (r & ~pol));
    endfunction

    function automatic logic [N-1:0] f_stat_write(input logic [N-1:0] old, input logic [DW-1:0] d);
        return d[0] ? (old | d[DW-1:1]) : (old & ~d[DW-1:1]);
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [DW-1:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic compare_all(input string tag);
        logic [DW-1:0] v;
        read_reg(2'd0, v); chk({tag, " R10 enable"}, v, {1'b0, m_en});
        read_reg(2'd1, v); chk({tag, " R10 polarity"}, v, {1'b0, m_pol});
        read_reg(2'd2, v); chk({tag, " R2 assert status"}, v, {m_sa, 1'b0});
        read_reg(2'd3, v); chk({tag, " R2 deassert status"}, v, {m_sd, 1'b0});
        chk({tag, " R8 irq assert"}, DW'(irq_a), DW'(|(m_sa & m_en)));
        chk({tag, " R8 irq deassert"}, DW'(irq_d), DW'(|(m_sd & m_en)));
    endtask

    // Drive on the falling edge, pass one rising edge, return at the next falling edge
    task automatic tick(input logic [N-1:0] p, input logic we, input logic [1:0] wa,
                        input logic [DW-1:0] wd);
        logic [N-1:0] ea, ed, sa_n, sd_n, en_n, pol_n;
        pins = p; wr_en = we; wr_addr = wa; wr_data = wd;
        ea = f_events(p, m_prev, m_pol, m_armed, 1'b1);
        ed = f_events(p, m_prev, m_pol, m_armed, 1'b0);
        sa_n = (we && wa == 2'd2) ? f_stat_write(m_sa, wd) : m_sa;
        sd_n = (we && wa == 2'd3) ? f_stat_write(m_sd, wd) : m_sd;
        en_n  = (we && wa == 2'd0) ? wd[N-1:0] : m_en;
        pol_n = (we && wa == 2'd1) ? wd[N-1:0] : m_pol;
        @(posedge clk);
        m_sa = sa_n | ea; m_sd = sd_n | ed;
        m_en = en_n; m_pol = pol_n; m_prev = p; m_armed = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [DW-1:0] v;
        void'($urandom(32'h1D5E_A7C3));
        // Reset with some pins already high (R9)
        pins = 31'h0000_000F;
        repeat (3) @(negedge clk);
        compare_all("R1 in reset");
        rst_n = 1'b1;
        #2;
        compare_all("R1 after reset");
        chk("R1 irq assert low", DW'(irq_a), '0);

        // R9: first sample after reset with pins high must not record edges
        tick(31'h0000_000F, 1'b0, 2'd0, '0);
        compare_all("R9 first sample");
        read_reg(2'd2, v); chk("R9 no assert event", v, '0);
        read_reg(2'd3, v); chk("R9 no deassert event", v, '0);

        // R10: configure enable and polarity
        tick(31'h0000_000F, 1'b1, 2'd0, 32'hFFFF_FFFF);
        tick(31'h0000_000F, 1'b1, 2'd1, 32'h0000_00FF);
        compare_all("R10 config");
        read_reg(2'd0, v); chk("R10 enable top bit zero", v, 32'h7FFF_FFFF);
        read_reg(2'd1, v); chk("R10 polarity value", v, 32'h0000_00FF);

        // R3: pin 4 polarity 1, rising -> assert bit 5
        tick(31'h0000_001F, 1'b0, 2'd0, '0);
        read_reg(2'd2, v); chk("R3 rise sets assert bit5 (R2)", v, 32'h0000_0020);
        chk("R3 irq assert high", DW'(irq_a), DW'(1));
        tick(31'h0000_000F, 1'b0, 2'd0, '0);
        read_reg(2'd3, v); chk("R3 fall sets deassert bit5", v, 32'h0000_0020);
        compare_all("R3 both");

        // R4: pin 8 polarity 0
        tick(31'h0000_010F, 1'b0, 2'd0, '0);
        read_reg(2'd3, v); chk("R4 rise sets deassert bit9", v, 32'h0000_0220);
        tick(31'h0000_000F, 1'b0, 2'd0, '0);
        read_reg(2'd2, v); chk("R4 fall sets assert bit9", v, 32'h0000_0220);
        compare_all("R4 both");

        // R5: clear pin 4 in assert status
        tick(31'h0000_000F, 1'b1, 2'd2, 32'h0000_0020);
        read_reg(2'd2, v); chk("R5 clear leaves others", v, 32'h0000_0200);

        // R6: set pin 30 in deassert status
        tick(31'h0000_000F, 1'b1, 2'd3, 32'h8000_0001);
        read_reg(2'd3, v); chk("R6 set bit31", v, 32'h8000_0220);

        // R7: rising edge on pin 4 with clear of the same bit
        tick(31'h0000_001F, 1'b1, 2'd2, 32'h0000_0020);
        read_reg(2'd2, v); chk("R7 edge beats clear", v, 32'h0000_0220);
        compare_all("R7");

        // R8: disable all, make an event, then enable only pin 0
        tick(31'h0000_001F, 1'b1, 2'd0, 32'h0000_0000);
        tick(31'h0000_001E, 1'b0, 2'd0, '0);
        read_reg(2'd3, v); chk("R8 latches while disabled", v, 32'h8000_0222);
        chk("R8 irq deassert gated off", DW'(irq_d), '0);
        tick(31'h0000_001E, 1'b1, 2'd0, 32'h0000_0001);
        chk("R8 irq deassert for pin0", DW'(irq_d), DW'(1));
        chk("R8 irq assert stays low", DW'(irq_a), '0);
        compare_all("R8");

        // Random phase
        for (int i = 0; i < 600; i++) begin
            logic [N-1:0] p;
            logic         we;
            p  = m_prev ^ (N'($urandom) & N'($urandom) & N'($urandom));
            we = ($urandom % 3) == 0;
            tick(p, we, 2'($urandom), DW'($urandom));
            compare_all("random R3 R4 R5 R6 R7");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule